// File: doc/BRIEF.md
# Spread-Spectrum Triangle Modulation Controller

This block produces the digital frequency-offset code that steers a spread-spectrum PLL. An accumulator adds a programmed increment once per reference cycle for a programmed number of cycles. It then subtracts the same increment for the same number of cycles, and repeats. The result is a fixed triangle whose shape cannot be changed. The code is presented in signed-magnitude form as a downward spread. The sign bit means "lower the frequency", and the magnitude is the accumulator value.

The period and increment seen at the inputs are not used directly. They are copied into shadow registers at defined moments. In normal mode the copy is made by an internally generated one-cycle load pulse. The pulse fires when modulation is enabled while the PLL is locked, or when the PLL gains lock while modulation is already enabled. In bypass mode no load pulse is used. Instead, the shadow registers follow the inputs on every cycle that the PLL is powered down. A configuration error is flagged when the loaded increment times the loaded period could overflow the 15-bit accumulator, and modulation is then held off.

Top module: `sscg_mod_ctrl`

## Requirements
- R1: After reset, `offset_o`, `param_valid_o` and `cfg_err_o` are all zero.
- R2: With `strobe_byp_i` low, a rise of `mod_en_i` while `pll_lock_i` is high loads the period and increment. `param_valid_o` is high from the next cycle. The output restarts from zero, and the first step appears one cycle after the load.
- R3: With `strobe_byp_i` low, a rise of `pll_lock_i` while `mod_en_i` is high loads the parameters with the same timing as R2.
- R4: With `strobe_byp_i` low, changes on `mod_period_i` or `inc_step_i` without a load pulse have no effect on `offset_o`.
- R5: While modulating with loaded period P and increment S, the magnitude after the m-th active cycle is k*S, where k = m mod 2P when that value is P or less, and 2P - (m mod 2P) otherwise. `offset_o[15]` is 1 exactly when the magnitude is nonzero, and `offset_o[14:0]` holds the magnitude.
- R6: Clearing `mod_en_i` or losing `pll_lock_i` returns the accumulator to zero, and `offset_o` reads zero on the next cycle.
- R7: With `strobe_byp_i` high, enable and lock edges load nothing. The shadow registers take the inputs on every cycle in which `pwr_down_i` is high, and `param_valid_o` is high on the following cycle. Input changes while powered up are ignored.
- R8: Modulation advances only while all of the following hold: `pll_lock_i` is high, `mod_en_i` is high, `pwr_down_i` is low, and parameters are valid. Otherwise `offset_o` is zero.
- R9: `cfg_err_o` is set at a load when the product of increment and period is 32767 or more, and it is cleared at a load when the product is smaller. While it is set, `offset_o` stays zero.
- R10: A loaded period of zero or a loaded increment of zero keeps `offset_o` at zero without raising `cfg_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_period_i | input | 13 | Half-period of the triangle in reference cycles |
| inc_step_i | input | 15 | Accumulator increment per cycle |
| mod_en_i | input | 1 | Modulation enable |
| strobe_byp_i | input | 1 | 1 = direct loading while powered down, 0 = load on internal pulse |
| pwr_down_i | input | 1 | PLL power-down status |
| pll_lock_i | input | 1 | PLL lock status |
| offset_o | output | 16 | Signed-magnitude offset code, bit 15 sign |
| param_valid_o | output | 1 | Shadow parameters have been loaded |
| cfg_err_o | output | 1 | Loaded increment times period is out of range |

## Verification
On every cycle, assertions check several properties. The load pulse never lasts two cycles, and each load is followed by a valid flag. Every active cycle moves the accumulator by exactly one increment, and the accumulator never exceeds the product of the loaded parameters. The output is zero on the cycle after lock is missing or the error flag is set. Only the directed scenarios can show that the magnitude follows the exact triangle sequence, that unstrobed or powered-up input changes are really ignored, and that each loading path picks up the intended values. The 32766/32767 boundary of the range check, and the idle behaviour with zero parameters, are likewise shown only by those scenarios.

// File: rtl/sscg_pkg.sv
package sscg_pkg;
  localparam int unsigned PERIOD_W_DEF = 13;
  localparam int unsigned STEP_W_DEF   = 15;
  localparam int unsigned ACC_W_DEF    = 15;

  typedef enum logic {
    PH_RISE = 1'b0,
    PH_FALL = 1'b1
  } ramp_phase_e;
endpackage

// File: rtl/sscg_load_ctrl.sv
module sscg_load_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic lock_i,
  input  logic byp_i,
  input  logic pwr_down_i,
  output logic load_o
);
  logic en_d, lock_d;
  logic pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d   <= 1'b0;
      lock_d <= 1'b0;
    end else begin
      en_d   <= en_i;
      lock_d <= lock_i;
    end
  end

  assign pulse  = (en_i & ~en_d & lock_i) | (lock_i & ~lock_d & en_i);
  assign load_o = byp_i ? pwr_down_i : pulse;

  // R2: the internal load pulse lasts a single cycle
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/sscg_param_shadow.sv
module sscg_param_shadow #(
  parameter int unsigned PERIOD_W = 13,
  parameter int unsigned STEP_W   = 15,
  parameter int unsigned ACC_W    = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [PERIOD_W-1:0] period_o,
  output logic [STEP_W-1:0]   step_o,
  output logic                valid_o,
  output logic                err_o
);
  localparam int unsigned PROD_W = PERIOD_W + STEP_W;
  localparam logic [PROD_W-1:0] LIMIT = PROD_W'((64'd1 << ACC_W) - 64'd1);

  logic [PROD_W-1:0] prod_in;
  assign prod_in = PROD_W'(period_i) * PROD_W'(step_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_o <= '0;
      step_o   <= '0;
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else if (load_i) begin
      period_o <= period_i;
      step_o   <= step_i;
      valid_o  <= 1'b1;
      err_o    <= (prod_in >= LIMIT);
    end
  end

  // R2 / R7: a load is followed by a valid flag
  p_valid_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> valid_o);
  // R4: without a load the shadow values stay put
  p_shadow_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(period_o) && $stable(step_o)));
endmodule

// File: rtl/sscg_tri_accum.sv
module sscg_tri_accum
  import sscg_pkg::*;
#(
  parameter int unsigned PERIOD_W = 13,
  parameter int unsigned STEP_W   = 15,
  parameter int unsigned ACC_W    = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [STEP_W-1:0]   step_i,
  output logic [ACC_W-1:0]    acc_o
);
  localparam int unsigned PROD_W = PERIOD_W + STEP_W;

  logic [PERIOD_W-1:0] cnt_q;
  ramp_phase_e         phase_q;
  logic                last_cnt;
  logic                idle_cfg;
  logic [ACC_W-1:0]    step_ext;

  assign last_cnt = (PROD_W'(cnt_q) + PROD_W'(1)) == PROD_W'(period_i);
  assign idle_cfg = (period_i == '0) || (step_i == '0);
  assign step_ext = ACC_W'(step_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i || idle_cfg) begin
      acc_o   <= '0;
      cnt_q   <= '0;
      phase_q <= PH_RISE;
    end else begin
      if (phase_q == PH_RISE) acc_o <= acc_o + step_ext;
      else                    acc_o <= acc_o - step_ext;
      if (last_cnt) begin
        cnt_q   <= '0;
        phase_q <= (phase_q == PH_RISE) ? PH_FALL : PH_RISE;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R5: each active cycle moves the accumulator by exactly one increment
  p_one_step_r5: assert property (@(posedge clk) disable iff (rst)
    (run_i && !idle_cfg) |=>
      ((acc_o == $past(acc_o) + ACC_W'($past(step_i))) ||
       (acc_o == $past(acc_o) - ACC_W'($past(step_i)))));
  // R9: the accumulator never exceeds the loaded product
  p_peak_bound_r9: assert property (@(posedge clk) disable iff (rst)
    PROD_W'(acc_o) <= PROD_W'(period_i) * PROD_W'(step_i));
endmodule

// File: rtl/sscg_mod_ctrl.sv
module sscg_mod_ctrl
  import sscg_pkg::*;
#(
  parameter int unsigned PERIOD_W = PERIOD_W_DEF,
  parameter int unsigned STEP_W   = STEP_W_DEF,
  parameter int unsigned ACC_W    = ACC_W_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PERIOD_W-1:0] mod_period_i,
  input  logic [STEP_W-1:0]   inc_step_i,
  input  logic                mod_en_i,
  input  logic                strobe_byp_i,
  input  logic                pwr_down_i,
  input  logic                pll_lock_i,
  output logic [ACC_W:0]      offset_o,
  output logic                param_valid_o,
  output logic                cfg_err_o
);
  logic                load;
  logic                run;
  logic [PERIOD_W-1:0] period_sh;
  logic [STEP_W-1:0]   step_sh;
  logic [ACC_W-1:0]    acc;

  sscg_load_ctrl u_load (
    .clk        (clk),
    .rst        (rst),
    .en_i       (mod_en_i),
    .lock_i     (pll_lock_i),
    .byp_i      (strobe_byp_i),
    .pwr_down_i (pwr_down_i),
    .load_o     (load)
  );

  sscg_param_shadow #(
    .PERIOD_W (PERIOD_W),
    .STEP_W   (STEP_W),
    .ACC_W    (ACC_W)
  ) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .period_i (mod_period_i),
    .step_i   (inc_step_i),
    .period_o (period_sh),
    .step_o   (step_sh),
    .valid_o  (param_valid_o),
    .err_o    (cfg_err_o)
  );

  assign run = param_valid_o & ~cfg_err_o & mod_en_i & pll_lock_i &
               ~pwr_down_i & ~load;

  sscg_tri_accum #(
    .PERIOD_W (PERIOD_W),
    .STEP_W   (STEP_W),
    .ACC_W    (ACC_W)
  ) u_accum (
    .clk      (clk),
    .rst      (rst),
    .run_i    (run),
    .period_i (period_sh),
    .step_i   (step_sh),
    .acc_o    (acc)
  );

  assign offset_o = {(acc != '0), acc};

  // R6 / R8: without lock the output is zero on the next cycle
  p_unlock_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !pll_lock_i |=> (offset_o == '0));
  // R9: an out-of-range configuration holds modulation off
  p_err_holds_off_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_err_o |=> (offset_o == '0));
  // R8: powered-down PLL gets no offset
  p_pwrdn_zero_r8: assert property (@(posedge clk) disable iff (rst)
    pwr_down_i |=> (offset_o == '0));
endmodule

// File: tb/sscg_mod_ctrl_tb.sv
`timescale 1ns/1ps
module sscg_mod_ctrl_tb;
  localparam real CYC = 4.0;

  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] mod_period_i;
  logic [14:0] inc_step_i;
  logic        mod_en_i, strobe_byp_i, pwr_down_i, pll_lock_i;
  logic [15:0] offset_o;
  logic        param_valid_o, cfg_err_o;

  int vectors = 0;
  int fails   = 0;

  always #(CYC/2) clk = ~clk;

  sscg_mod_ctrl u_dut (
    .clk           (clk),
    .rst           (rst),
    .mod_period_i  (mod_period_i),
    .inc_step_i    (inc_step_i),
    .mod_en_i      (mod_en_i),
    .strobe_byp_i  (strobe_byp_i),
    .pwr_down_i    (pwr_down_i),
    .pll_lock_i    (pll_lock_i),
    .offset_o      (offset_o),
    .param_valid_o (param_valid_o),
    .cfg_err_o     (cfg_err_o)
  );

  function automatic int tri_val(int m, int p, int s);
    int ph = m % (2 * p);
    return (ph <= p) ? ph * s : (2 * p - ph) * s;
  endfunction

  function automatic logic [15:0] enc(int mag);
    return {(mag != 0), 15'(mag)};
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step_clk();
    @(negedge clk);
  endtask

  task automatic run_tri(string tag, int p, int s, int m0, int n);
    for (int m = m0; m < m0 + n; m++) begin
      step_clk();
      chk(tag, int'(offset_o), int'(enc(tri_val(m, p, s))));
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    mod_period_i = '0; inc_step_i = '0;
    mod_en_i = 1'b0; strobe_byp_i = 1'b0;
    pwr_down_i = 1'b0; pll_lock_i = 1'b0;
    repeat (3) step_clk();
    rst = 1'b0;
    step_clk();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 offset", int'(offset_o), 0);
    chk("R1 valid", int'(param_valid_o), 0);
    chk("R1 err", int'(cfg_err_o), 0);
  endtask

  task automatic t_strobe_paths();
    pll_lock_i = 1'b1; mod_period_i = 13'd4; inc_step_i = 15'd100;
    step_clk();
    chk("R2 no load yet", int'(param_valid_o), 0);
    mod_en_i = 1'b1;
    step_clk();
    chk("R2 valid", int'(param_valid_o), 1);
    chk("R2 restart", int'(offset_o), 0);
    run_tri("R5 tri 4x100", 4, 100, 1, 20);
    mod_period_i = 13'd7; inc_step_i = 15'd5;
    run_tri("R4 unstrobed change", 4, 100, 21, 8);
    mod_en_i = 1'b0;
    step_clk();
    chk("R6 enable cleared", int'(offset_o), 0);
    step_clk();
    chk("R8 disabled", int'(offset_o), 0);
    mod_en_i = 1'b1;
    step_clk();
    chk("R2 reload restart", int'(offset_o), 0);
    run_tri("R2 new params 7x5", 7, 5, 1, 16);
    pll_lock_i = 1'b0;
    step_clk();
    chk("R6 lock lost", int'(offset_o), 0);
    mod_period_i = 13'd3; inc_step_i = 15'd1000;
    step_clk();
    chk("R8 unlocked", int'(offset_o), 0);
    pll_lock_i = 1'b1;
    step_clk();
    chk("R3 lock rise restart", int'(offset_o), 0);
    run_tri("R3 params 3x1000", 3, 1000, 1, 10);
  endtask

  task automatic t_bypass();
    do_reset();
    strobe_byp_i = 1'b1; pll_lock_i = 1'b1;
    mod_period_i = 13'd5; inc_step_i = 15'd50;
    mod_en_i = 1'b1;
    step_clk();
    chk("R7 edges ignored", int'(param_valid_o), 0);
    step_clk();
    chk("R7 no output", int'(offset_o), 0);
    pwr_down_i = 1'b1;
    step_clk();
    chk("R7 direct load", int'(param_valid_o), 1);
    chk("R8 powered down", int'(offset_o), 0);
    pwr_down_i = 1'b0;
    run_tri("R7 tri 5x50", 5, 50, 1, 12);
    mod_period_i = 13'd2; inc_step_i = 15'd9;
    run_tri("R7 powered-up change", 5, 50, 13, 8);
  endtask

  task automatic t_range();
    do_reset();
    pll_lock_i = 1'b1; mod_period_i = 13'd200; inc_step_i = 15'd200;
    mod_en_i = 1'b1;
    step_clk();
    chk("R9 err set", int'(cfg_err_o), 1);
    for (int i = 0; i < 5; i++) begin
      step_clk();
      chk("R9 held off", int'(offset_o), 0);
    end
    mod_en_i = 1'b0;
    step_clk();
    mod_period_i = 13'd2; inc_step_i = 15'd16383;
    mod_en_i = 1'b1;
    step_clk();
    chk("R9 32766 accepted", int'(cfg_err_o), 0);
    run_tri("R9 peak 32766", 2, 16383, 1, 6);
    mod_en_i = 1'b0;
    step_clk();
    mod_period_i = 13'd1; inc_step_i = 15'd32767;
    mod_en_i = 1'b1;
    step_clk();
    chk("R9 32767 rejected", int'(cfg_err_o), 1);
    step_clk();
    chk("R9 output zero", int'(offset_o), 0);
  endtask

  task automatic t_zero_cfg();
    mod_en_i = 1'b0;
    step_clk();
    mod_period_i = 13'd0; inc_step_i = 15'd100;
    mod_en_i = 1'b1;
    step_clk();
    chk("R10 zero period no err", int'(cfg_err_o), 0);
    for (int i = 0; i < 4; i++) begin
      step_clk();
      chk("R10 zero period", int'(offset_o), 0);
    end
    mod_en_i = 1'b0;
    step_clk();
    mod_period_i = 13'd5; inc_step_i = 15'd0;
    mod_en_i = 1'b1;
    step_clk();
    chk("R10 zero step no err", int'(cfg_err_o), 0);
    for (int i = 0; i < 4; i++) begin
      step_clk();
      chk("R10 zero step", int'(offset_o), 0);
    end
  endtask

  initial begin
    t_reset();
    t_strobe_paths();
    t_bypass();
    t_range();
    t_zero_cfg();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CYC * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule